// File: doc/BRIEF.md
# Dual-Axis Galvanometer Command Frame Receiver

This block receives a synchronous serial command link that steers a pair of galvanometer mirrors. The link carries four wires: a bit clock of about 2 MHz, a frame-start line and two data lines, one for each axis. A frame on each data line is 20 bits long. It carries a 3-bit control code, then a 16-bit unsigned position word that spans the mirror's full rotation range, then an even-parity bit. The two axes are sent side by side and share the clock and the frame-start line.

The receiver runs on a fast system clock. All four link wires pass through two-flop synchronizers. The receiver finds the falling edges of the link clock and the rising edges of the frame-start line, and shifts each data line into its own per-axis shift register. A two-state machine sequences the frame. ST_IDLE waits for a frame start. The transition start (ST_IDLE to ST_RECV) fires on a rising frame-start edge and clears the bit count. In ST_RECV, the transition shift (ST_RECV to ST_RECV) fires on each falling clock edge and counts one bit.

When the 20th bit arrives, the machine takes one of two transitions:
- finish (ST_RECV to ST_IDLE) when no new frame start comes with that bit.
- chain (ST_RECV to ST_RECV, count cleared) when a new frame start comes in the same cycle.

Both transitions publish the two positions, the per-axis error flags and a one-cycle valid strobe. If a frame start arrives before the frame is complete, the transition abort (ST_RECV to ST_RECV, count cleared) drops the partial frame and pulses a framing-error flag.

Top module: `galvo_frame_rx`

## Requirements
- R1: After the active-low asynchronous reset is asserted, every output is 0 and no valid pulse is issued until a full frame has been received.
- R2: Bits are taken on falling edges of the link clock, in this order: bit 0 to bit 2 are control code C2, C1, C0. Bit 3 to bit 18 are position bits 15 down to 0, most significant bit first. Bit 19 is parity. The published position of each axis equals its received 16-bit field.
- R3: The code-error flag of an axis is 1 when the received C2..C0 differs from 3'b001, and 0 when it equals 3'b001.
- R4: The parity-error flag of an axis is 1 when the XOR of all 20 received bits of that axis is 1, and 0 otherwise.
- R5: Each complete frame produces exactly one `frame_valid` pulse, one system cycle wide. Both axes' positions and flags are updated in that same cycle.
- R6: A rising edge of the frame-start line before 20 bits have arrived discards the partial frame. It produces a one-cycle `frame_err` pulse and no `frame_valid` pulse. Bit counting restarts from bit 0.
- R7: Link clock edges that arrive while no frame has been started are ignored: they produce no `frame_valid` and they change no output.
- R8: A frame-start rising edge in the same cycle as the 20th falling clock edge still publishes the completed frame, with no `frame_err`. It also starts the next frame.
- R9: Between `frame_valid` pulses, the positions and the error flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lnk_clk | input | 1 | Link bit clock; data is taken on its falling edge |
| lnk_sync | input | 1 | Frame-start line; a rising edge begins a frame |
| lnk_dx | input | 1 | X-axis serial data |
| lnk_dy | input | 1 | Y-axis serial data |
| x_pos | output | 16 | Last published X position |
| y_pos | output | 16 | Last published Y position |
| x_code_err | output | 1 | X control code was not 3'b001 |
| x_par_err | output | 1 | X parity check failed |
| y_code_err | output | 1 | Y control code was not 3'b001 |
| y_par_err | output | 1 | Y parity check failed |
| frame_valid | output | 1 | One-cycle strobe for a newly published frame |
| frame_err | output | 1 | One-cycle strobe for a discarded partial frame |

## Verification
Two functions can fall in the same system cycle: completing a frame on its 20th falling clock edge, and starting a new frame on a rising frame-start edge. The bench provokes this by driving the final clock fall and the frame-start rise at the same instant. Both wires pass through synchronizers of equal depth, so the receiver sees the two edges in one cycle. The bench judges the result by its effects. Two valid pulses must follow, the first carrying the old frame and the second the chained frame. The framing-error count must not change.

// File: rtl/galvo_rx_pkg.sv
package galvo_rx_pkg;
    localparam int CODE_W     = 3;
    localparam int POS_W      = 16;
    localparam int FRAME_BITS = CODE_W + POS_W + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int AXES       = 2;
    localparam logic [CODE_W-1:0] CODE_OK = 3'b001;

    typedef enum logic {ST_IDLE, ST_RECV} rx_state_t;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             code_err;
        logic             par_err;
    } axis_res_t;
endpackage

// File: rtl/galvo_rx_sync.sv
module galvo_rx_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/galvo_axis_shift.sv
module galvo_axis_shift
    import galvo_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      shift_en,
    input  logic      din,
    output axis_res_t res
);
    logic [FRAME_BITS-2:0] sh_q;
    logic [FRAME_BITS-1:0] word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sh_q <= '0;
        else if (shift_en) sh_q <= {sh_q[FRAME_BITS-3:0], din};
    end

    // The word includes the bit being taken this cycle.
    assign word         = {sh_q, din};
    assign res.pos      = word[POS_W:1];
    assign res.code_err = (word[FRAME_BITS-1 -: CODE_W] != CODE_OK);
    assign res.par_err  = ^word;
endmodule

// File: rtl/galvo_frame_rx.sv
module galvo_frame_rx
    import galvo_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lnk_clk,
    input  logic             lnk_sync,
    input  logic             lnk_dx,
    input  logic             lnk_dy,
    output logic [POS_W-1:0] x_pos,
    output logic [POS_W-1:0] y_pos,
    output logic             x_code_err,
    output logic             x_par_err,
    output logic             y_code_err,
    output logic             y_par_err,
    output logic             frame_valid,
    output logic             frame_err
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic [3:0] raw_w, syn_w;
    logic       clk_prev, sync_prev;
    logic       fall, rise, last, abort, shift_en;
    rx_state_t  state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic      din_ax [AXES];
    axis_res_t res_ax [AXES];

    assign raw_w = {lnk_clk, lnk_sync, lnk_dx, lnk_dy};

    galvo_rx_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_w), .q(syn_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev  <= 1'b0;
            sync_prev <= 1'b0;
        end else begin
            clk_prev  <= syn_w[3];
            sync_prev <= syn_w[2];
        end
    end

    assign fall     = clk_prev & ~syn_w[3];
    assign rise     = syn_w[2] & ~sync_prev;
    assign last     = (state_q == ST_RECV) && fall && (cnt_q == LAST_BIT);
    assign abort    = (state_q == ST_RECV) && rise && !last;
    assign shift_en = (state_q == ST_RECV) && fall && !abort;

    assign din_ax[0] = syn_w[1];
    assign din_ax[1] = syn_w[0];

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        galvo_axis_shift u_axis (
            .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
            .din(din_ax[a]), .res(res_ax[a])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rise) begin            // start
                    state_d = ST_RECV;
                    cnt_d   = '0;
                end
            end
            ST_RECV: begin
                if (last) begin            // chain or finish
                    state_d = rise ? ST_RECV : ST_IDLE;
                    cnt_d   = '0;
                end else if (rise) begin   // abort
                    cnt_d   = '0;
                end else if (fall) begin   // shift
                    cnt_d   = cnt_q + 1'b1;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_pos       <= '0;
            y_pos       <= '0;
            x_code_err  <= 1'b0;
            x_par_err   <= 1'b0;
            y_code_err  <= 1'b0;
            y_par_err   <= 1'b0;
            frame_valid <= 1'b0;
            frame_err   <= 1'b0;
        end else begin
            frame_valid <= last;
            frame_err   <= abort;
            if (last) begin
                x_pos      <= res_ax[0].pos;
                x_code_err <= res_ax[0].code_err;
                x_par_err  <= res_ax[0].par_err;
                y_pos      <= res_ax[1].pos;
                y_code_err <= res_ax[1].code_err;
                y_par_err  <= res_ax[1].par_err;
            end
        end
    end

    // Assertions
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_BIT);
    assert_idle_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cnt_q == '0));
    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);
    assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);
    assert_no_valid_with_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && frame_err));
    assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(x_pos) && $stable(y_pos) &&
                          $stable(x_code_err) && $stable(y_par_err)));
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !frame_valid);
endmodule

// File: tb/galvo_frame_rx_test.sv
module galvo_frame_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lnk_clk = 1'b0, lnk_sync = 1'b0, lnk_dx = 1'b0, lnk_dy = 1'b0;
    logic [15:0] x_pos, y_pos;
    logic x_code_err, x_par_err, y_code_err, y_par_err, frame_valid, frame_err;

    int n_tests = 0;
    int n_fail  = 0;
    int vcnt    = 0;
    int ecnt    = 0;
    int wide    = 0;
    logic prev_v = 1'b0;
    logic [15:0] cap_x [32];
    logic [15:0] cap_y [32];

    always #4 clk = ~clk;   // 125 MHz

    galvo_frame_rx uut (
        .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_sync(lnk_sync),
        .lnk_dx(lnk_dx), .lnk_dy(lnk_dy), .x_pos(x_pos), .y_pos(y_pos),
        .x_code_err(x_code_err), .x_par_err(x_par_err),
        .y_code_err(y_code_err), .y_par_err(y_par_err),
        .frame_valid(frame_valid), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) begin
                if (vcnt < 32) begin
                    cap_x[vcnt] = x_pos;
                    cap_y[vcnt] = y_pos;
                end
                vcnt++;
            end
            if (frame_err) ecnt++;
            if (frame_valid && prev_v) wide++;
        end
        prev_v = frame_valid;
    end

    // {xcode[39:37], xdata[36:21], xflip[20], ycode[19:17], ydata[16:1], yflip[0]}
    localparam logic [39:0] VEC [6] = '{
        {3'b001, 16'h0000, 1'b0, 3'b001, 16'hFFFF, 1'b0},
        {3'b001, 16'hA5C3, 1'b0, 3'b001, 16'h1234, 1'b1},
        {3'b000, 16'h8001, 1'b0, 3'b001, 16'h7FFE, 1'b0},
        {3'b101, 16'hFFFF, 1'b1, 3'b111, 16'h0001, 1'b1},
        {3'b001, 16'h0001, 1'b0, 3'b001, 16'h8000, 1'b0},
        {3'b001, 16'h5555, 1'b1, 3'b011, 16'hAAAA, 1'b0}
    };

    function automatic logic [19:0] mk(input logic [2:0] c, input logic [15:0] d, input logic f);
        return {c, d, (^{c, d}) ^ f};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic send(input logic [19:0] fx, input logic [19:0] fy, input int nbits,
                        input bit gap, input bit raise_end);
        if (gap) begin
            lnk_sync = 1'b0;
            #104;
        end
        for (int i = 0; i < nbits; i++) begin
            lnk_dx   = fx[19-i];
            lnk_dy   = fy[19-i];
            lnk_sync = (i < 19);
            lnk_clk  = 1'b1;
            #252;
            lnk_clk  = 1'b0;
            if (raise_end && i == nbits - 1) lnk_sync = 1'b1;
            #252;
        end
    endtask

    bit done = 1'b0;

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [19:0] fa, fb;
        int v0, e0;
        #41;
        // R1: reset state
        chk("R1 pos", {x_pos, y_pos}, 32'h0);
        chk("R1 flags", {26'h0, x_code_err, x_par_err, y_code_err, y_par_err, frame_valid, frame_err}, 32'h0);
        rst_n = 1'b1;
        #104;
        chk("R1 no valid", vcnt, 0);

        // Table walk: R2, R3, R4, R5
        foreach (VEC[k]) begin
            logic [39:0] e;
            e  = VEC[k];
            v0 = vcnt;
            send(mk(e[39:37], e[36:21], e[20]), mk(e[19:17], e[16:1], e[0]), 20, 1'b1, 1'b0);
            #200;
            chk("R5 one valid", vcnt, v0 + 1);
            chk("R2 x_pos", x_pos, e[36:21]);
            chk("R2 y_pos", y_pos, e[16:1]);
            chk("R3 x_code_err", x_code_err, e[39:37] != 3'b001);
            chk("R3 y_code_err", y_code_err, e[19:17] != 3'b001);
            chk("R4 x_par_err", x_par_err, e[20]);
            chk("R4 y_par_err", y_par_err, e[0]);
        end

        // R7: clock activity with no frame start
        v0 = vcnt;
        lnk_sync = 1'b0;
        for (int i = 0; i < 25; i++) begin
            lnk_dx = i[0]; lnk_dy = ~i[0];
            lnk_clk = 1'b1; #252; lnk_clk = 1'b0; #252;
        end
        #200;
        chk("R7 no valid", vcnt, v0);
        chk("R7 x_pos unchanged", x_pos, 16'h5555);
        chk("R9 y_pos held", y_pos, 16'hAAAA);

        // R6: aborted frame, then full frame
        v0 = vcnt; e0 = ecnt;
        fa = mk(3'b001, 16'hDEAD, 1'b0);
        fb = mk(3'b001, 16'hBEEF, 1'b0);
        send(fa, fb, 10, 1'b1, 1'b0);
        send(fb, fa, 20, 1'b1, 1'b0);
        #200;
        chk("R6 frame_err pulse", ecnt, e0 + 1);
        chk("R6 one valid", vcnt, v0 + 1);
        chk("R6 x_pos after restart", x_pos, 16'hBEEF);
        chk("R6 y_pos after restart", y_pos, 16'hDEAD);

        // R8: frame start coincides with 20th bit
        v0 = vcnt; e0 = ecnt;
        fa = mk(3'b001, 16'h1357, 1'b0);
        fb = mk(3'b001, 16'h2468, 1'b0);
        send(fa, fb, 20, 1'b1, 1'b1);
        send(fb, fa, 20, 1'b0, 1'b0);
        #200;
        chk("R8 two valids", vcnt, v0 + 2);
        chk("R8 no frame_err", ecnt, e0);
        if (v0 + 1 < 32) begin
            chk("R8 first frame x", cap_x[v0], 16'h1357);
            chk("R8 chained frame x", cap_x[v0+1], 16'h2468);
            chk("R8 chained frame y", cap_y[v0+1], 16'h1357);
        end

        // R1: reset in mid-frame, then recovery
        send(fa, fb, 8, 1'b1, 1'b0);
        #1;
        rst_n = 1'b0;
        #20;
        chk("R1 mid-frame reset pos", {x_pos, y_pos}, 32'h0);
        chk("R1 mid-frame reset valid", frame_valid, 1'b0);
        #1;
        rst_n = 1'b1;
        v0 = vcnt;
        send(mk(3'b001, 16'h0F0F, 1'b0), mk(3'b110, 16'hF0F0, 1'b0), 20, 1'b1, 1'b0);
        #200;
        chk("R5 valid after reset", vcnt, v0 + 1);
        chk("R2 x after reset", x_pos, 16'h0F0F);
        chk("R3 y code after reset", y_code_err, 1'b1);

        chk("R5 pulse width one cycle", wide, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule